// File: doc/BRIEF.md
# Translation Window Replay Walker

This block walks a translated address window from address zero upward and reports every live mapping. A start pulse begins a walk. At each step the walker sends one lookup to an external translator. When the answer carries an access permission, the walker passes it on as a notification. The walker uses no storage for the mappings: it generates addresses and forwards what the translator returns.

The step is one page, and the page size is set by a shift value. The window size is the entry count shifted left by that same value. Both configuration values are sampled when the walk starts. A control bit lets the walk be skipped entirely. The walk also stops cleanly when the next address would run past the top of the address space.

There is only ever one lookup in flight. A notification is held until the consumer accepts it, and only then does the walker move to the next page.

Top module: `xlat_replay_walker`

## Requirements
- R1: After reset, `busy`, `done`, `lookupValid` and `notifyValid` are all low.
- R2: A walk issues one-cycle lookups at addresses 0, S, 2S, … in strictly increasing order, where S = 1 << `cfgShift`. It keeps issuing while the address is below `cfgCount << cfgShift`, so it makes `cfgCount` lookups when no wrap occurs.
- R3: The permission field is 2 bits: 00 means no access, 01 read, 10 write, 11 read/write. A lookup answered with 00 produces no notification. Any other answer produces exactly one notification, carrying the lookup address on `notifyIova` and the returned translated address and permission.
- R4: Only one lookup is outstanding at a time. While `notifyValid` is high and `notifyReady` is low, the notification holds steady and no new lookup is issued.
- R5: If adding S to the current address would carry out of `ADDR_W` bits, the walk finishes after that step without wrapping back to zero.
- R6: A start accepted while `skipReplay` is high pulses `done` in the next cycle and issues no lookup.
- R7: `done` is high for exactly one cycle per walk. A `start` seen while `busy` is high is ignored.
- R8: With `cfgCount` equal to zero, the walk finishes with no lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| skipReplay | input | 1 | Finish a started walk at once |
| cfgShift | input | SHIFT_W | Page shift |
| cfgCount | input | CNT_W | Number of window entries |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| lookupValid | output | 1 | Lookup request strobe |
| lookupAddr | output | ADDR_W | Address being looked up |
| respValid | input | 1 | Translator answer strobe |
| respXlat | input | ADDR_W | Translated address from the translator |
| respPerm | input | 2 | Permission from the translator |
| notifyValid | output | 1 | Mapping notification valid |
| notifyReady | input | 1 | Consumer accepts the notification |
| notifyIova | output | ADDR_W | Input address of the mapping |
| notifyXlat | output | ADDR_W | Translated address of the mapping |
| notifyPerm | output | 2 | Permission of the mapping |

## Verification
The bench builds the walker with a 16-bit address, an 8-bit entry count and a 4-bit shift. With 4 KiB pages and 16 entries, the window then ends exactly at the top of the address space, so the wrap stop of R5 is reached in a few dozen cycles. Single-byte steps and small windows exercise the shift at both of its extremes. An irregular ready pattern and varying translator latency stress the holding rule of R4.

// File: rtl/xlat_replay_pkg.sv
package xlat_replay_pkg;
  // Strobes from the sequencer to the address datapath.
  typedef struct packed {
    logic load;     // clear the address and latch the configuration
    logic capture;  // register the translator answer
    logic advance;  // move to the next page
  } walkCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT,
    ST_NOTIFY,
    ST_FINISH
  } walkState_t;
endpackage

// File: rtl/xlat_replay_dp.sv
module xlat_replay_dp
  import xlat_replay_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int CNT_W   = 32,
  parameter int SHIFT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  walkCtl_t           ctl,
  input  logic [SHIFT_W-1:0] cfgShift,
  input  logic [CNT_W-1:0]   cfgCount,
  input  logic [ADDR_W-1:0]  respXlat,
  input  logic [1:0]         respPerm,
  output logic [ADDR_W-1:0]  curAddr,
  output logic               inWindow,
  output logic               wrapNext,
  output logic [ADDR_W-1:0]  heldXlat,
  output logic [1:0]         heldPerm
);
  localparam int WIN_W = ADDR_W + 1;

  logic [SHIFT_W-1:0] shiftQ;
  logic [WIN_W-1:0]   windowQ;
  logic [ADDR_W-1:0]  step;
  logic [WIN_W-1:0]   nextWide;

  assign step     = ADDR_W'(1) << shiftQ;
  assign nextWide = {1'b0, curAddr} + {1'b0, step};
  assign wrapNext = nextWide[ADDR_W];
  assign inWindow = {1'b0, curAddr} < windowQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr  <= '0;
      shiftQ   <= '0;
      windowQ  <= '0;
      heldXlat <= '0;
      heldPerm <= '0;
    end else begin
      if (ctl.load) begin
        curAddr <= '0;
        shiftQ  <= cfgShift;
        windowQ <= WIN_W'(cfgCount) << cfgShift;
      end else if (ctl.advance) begin
        curAddr <= nextWide[ADDR_W-1:0];
      end
      if (ctl.capture) begin
        heldXlat <= respXlat;
        heldPerm <= respPerm;
      end
    end
  end
endmodule

// File: rtl/xlat_replay_ctrl.sv
module xlat_replay_ctrl
  import xlat_replay_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     skipReplay,
  input  logic     inWindow,
  input  logic     wrapNext,
  input  logic     respValid,
  input  logic [1:0] respPerm,
  input  logic     notifyReady,
  output walkCtl_t ctl,
  output logic     lookupValid,
  output logic     notifyValid,
  output logic     busy,
  output logic     done
);
  walkState_t state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt = state;
    ctl = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (skipReplay) begin
            nxt = ST_FINISH;
          end else begin
            ctl.load = 1'b1;
            nxt      = ST_CHECK;
          end
        end
      end
      ST_CHECK: nxt = inWindow ? ST_WAIT : ST_FINISH;
      ST_WAIT: begin
        if (respValid) begin
          ctl.capture = 1'b1;
          if (respPerm != 2'b00) begin
            nxt = ST_NOTIFY;
          end else if (wrapNext) begin
            nxt = ST_FINISH;
          end else begin
            ctl.advance = 1'b1;
            nxt         = ST_CHECK;
          end
        end
      end
      ST_NOTIFY: begin
        if (notifyReady) begin
          if (wrapNext) begin
            nxt = ST_FINISH;
          end else begin
            ctl.advance = 1'b1;
            nxt         = ST_CHECK;
          end
        end
      end
      ST_FINISH: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign lookupValid = (state == ST_CHECK) && inWindow;
  assign notifyValid = (state == ST_NOTIFY);
  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_FINISH);
endmodule

// File: rtl/xlat_replay_walker.sv
module xlat_replay_walker
  import xlat_replay_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int CNT_W   = 32,
  parameter int SHIFT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               skipReplay,
  input  logic [SHIFT_W-1:0] cfgShift,
  input  logic [CNT_W-1:0]   cfgCount,
  output logic               busy,
  output logic               done,
  output logic               lookupValid,
  output logic [ADDR_W-1:0]  lookupAddr,
  input  logic               respValid,
  input  logic [ADDR_W-1:0]  respXlat,
  input  logic [1:0]         respPerm,
  output logic               notifyValid,
  input  logic               notifyReady,
  output logic [ADDR_W-1:0]  notifyIova,
  output logic [ADDR_W-1:0]  notifyXlat,
  output logic [1:0]         notifyPerm
);
  walkCtl_t          ctl;
  logic              inWindow;
  logic              wrapNext;
  logic [ADDR_W-1:0] curAddr;

  xlat_replay_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .skipReplay  (skipReplay),
    .inWindow    (inWindow),
    .wrapNext    (wrapNext),
    .respValid   (respValid),
    .respPerm    (respPerm),
    .notifyReady (notifyReady),
    .ctl         (ctl),
    .lookupValid (lookupValid),
    .notifyValid (notifyValid),
    .busy        (busy),
    .done        (done)
  );

  xlat_replay_dp #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .SHIFT_W (SHIFT_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .cfgShift (cfgShift),
    .cfgCount (cfgCount),
    .respXlat (respXlat),
    .respPerm (respPerm),
    .curAddr  (curAddr),
    .inWindow (inWindow),
    .wrapNext (wrapNext),
    .heldXlat (notifyXlat),
    .heldPerm (notifyPerm)
  );

  assign lookupAddr = curAddr;
  assign notifyIova = curAddr;
endmodule

// File: rtl/xlat_replay_checker.sv
module xlat_replay_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              skipReplay,
  input logic              busy,
  input logic              done,
  input logic              lookupValid,
  input logic [ADDR_W-1:0] lookupAddr,
  input logic              notifyValid,
  input logic              notifyReady,
  input logic [ADDR_W-1:0] notifyIova,
  input logic [ADDR_W-1:0] notifyXlat,
  input logic [1:0]        notifyPerm
);
  logic              seenLookup;
  logic [ADDR_W-1:0] lastAddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seenLookup <= 1'b0;
      lastAddr   <= '0;
    end else if (done) begin
      seenLookup <= 1'b0;
    end else if (lookupValid) begin
      seenLookup <= 1'b1;
      lastAddr   <= lookupAddr;
    end
  end

  AST_ADDR_RISING: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid && seenLookup |-> lookupAddr > lastAddr); // R2 R5

  AST_NO_EMPTY_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
    notifyValid |-> notifyPerm != 2'b00); // R3

  AST_NOTIFY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    notifyValid && !notifyReady |=> notifyValid && $stable(notifyIova)
      && $stable(notifyXlat) && $stable(notifyPerm)); // R4

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid |-> !notifyValid); // R4

  AST_SKIP_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    start && skipReplay && !busy |=> done && !lookupValid); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R7
endmodule

bind xlat_replay_walker xlat_replay_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .skipReplay  (skipReplay),
  .busy        (busy),
  .done        (done),
  .lookupValid (lookupValid),
  .lookupAddr  (lookupAddr),
  .notifyValid (notifyValid),
  .notifyReady (notifyReady),
  .notifyIova  (notifyIova),
  .notifyXlat  (notifyXlat),
  .notifyPerm  (notifyPerm)
);

// File: tb/xlat_replay_walker_tb.sv
module xlat_replay_walker_tb;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          skipReplay = 1'b0;
  logic [SW-1:0] cfgShift = '0;
  logic [CW-1:0] cfgCount = '0;
  logic          busy, done, lookupValid, notifyValid;
  logic [AW-1:0] lookupAddr, notifyIova, notifyXlat;
  logic [1:0]    notifyPerm;
  logic          respValid = 1'b0;
  logic [AW-1:0] respXlat = '0;
  logic [1:0]    respPerm = '0;
  logic          notifyReady = 1'b0;

  int tests = 0, fails = 0;
  int lookCnt = 0, doneCnt = 0, expIdx = 0, cycles = 0;
  int curShift = 0, curSeed = 0;
  logic [2*AW+1:0] expQ[$];
  logic [7:0] lfsr = 8'hA5;

  always #10 clk = ~clk; // 50 MHz

  xlat_replay_walker #(.ADDR_W(AW), .CNT_W(CW), .SHIFT_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .skipReplay(skipReplay),
    .cfgShift(cfgShift), .cfgCount(cfgCount), .busy(busy), .done(done),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .respValid(respValid), .respXlat(respXlat), .respPerm(respPerm),
    .notifyValid(notifyValid), .notifyReady(notifyReady),
    .notifyIova(notifyIova), .notifyXlat(notifyXlat), .notifyPerm(notifyPerm)
  );

  task automatic chk(input bit ok, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [1:0] permOf(input int idx);
    return 2'((idx + curSeed) % 4);
  endfunction

  function automatic logic [AW-1:0] xlatOf(input logic [AW-1:0] a);
    return a ^ 16'h5A00;
  endfunction

  // Translator model: answers each lookup after a short variable latency.
  int pend = 0, lat = 0;
  logic [AW-1:0] pendAddr;
  always @(negedge clk) begin
    respValid = 1'b0;
    if (lookupValid) begin
      chk(lookupAddr == AW'(expIdx << curShift),
          $sformatf("R2 lookup addr act=%h exp=%h", lookupAddr, AW'(expIdx << curShift)));
      pendAddr = lookupAddr;
      lat = expIdx % 3;
      pend = 1;
      expIdx++;
      lookCnt++;
    end else if (pend != 0) begin
      if (lat == 0) begin
        respValid = 1'b1;
        respXlat  = xlatOf(pendAddr);
        respPerm  = permOf(int'(pendAddr >> curShift));
        pend = 0;
      end else begin
        lat--;
      end
    end
  end

  // Monitor: irregular ready, pops the scoreboard on each handshake.
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    notifyReady = lfsr[0] | lfsr[2];
    if (done) doneCnt++;
    if (notifyValid && notifyReady) begin
      if (expQ.size() == 0) begin
        chk(1'b0, $sformatf("R3 unexpected notification act=%h exp=none", notifyIova));
      end else begin
        logic [2*AW+1:0] e;
        e = expQ.pop_front();
        chk({notifyIova, notifyXlat, notifyPerm} == e,
            $sformatf("R3 notification act=%h exp=%h", {notifyIova, notifyXlat, notifyPerm}, e));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic runWalk(input int sh, input int cnt, input bit skip, input int seed,
                         input bit poke, input int expLooks, input string tag);
    int d0, w;
    curShift = sh; curSeed = seed; expIdx = 0; lookCnt = 0;
    if (!skip) begin
      for (int i = 0; i < expLooks; i++) begin
        logic [AW-1:0] a;
        a = AW'(i << sh);
        if (permOf(i) != 2'b00) expQ.push_back({a, xlatOf(a), permOf(i)});
      end
    end
    d0 = doneCnt;
    @(negedge clk);
    cfgShift = SW'(sh); cfgCount = CW'(cnt); skipReplay = skip; start = 1'b1;
    @(negedge clk);
    start = 1'b0; skipReplay = 1'b0;
    if (skip) chk(done == 1'b1, $sformatf("R6 done after skip act=%0b exp=1", done));
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; skipReplay = 1'b1; cfgCount = 8'd1;
      @(negedge clk);
      start = 1'b0; skipReplay = 1'b0;
    end
    w = 0;
    while (!done && w < 2000) begin @(negedge clk); w++; end
    chk(done == 1'b1, $sformatf("%s done seen act=%0b exp=1", tag, done));
    @(negedge clk);
    chk(done == 1'b0, $sformatf("R7 done width act=%0b exp=0", done));
    repeat (4) @(negedge clk);
    chk(doneCnt - d0 == 1, $sformatf("R7 done pulses act=%0d exp=1", doneCnt - d0));
    chk(lookCnt == expLooks, $sformatf("%s lookups act=%0d exp=%0d", tag, lookCnt, expLooks));
    chk(expQ.size() == 0, $sformatf("R3 leftover notifications act=%0d exp=0", expQ.size()));
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !lookupValid && !notifyValid,
        $sformatf("R1 reset outputs act=%0b%0b%0b%0b exp=0000", busy, done, lookupValid, notifyValid));
    rst_n = 1'b1;
    @(negedge clk);
    runWalk(4, 8, 1'b0, 0, 1'b0, 8, "R2");        // mixed permissions
    runWalk(0, 5, 1'b0, 3, 1'b0, 5, "R2");        // single-byte step
    runWalk(12, 16, 1'b0, 1, 1'b0, 16, "R5");     // ends at top of space
    runWalk(4, 0, 1'b0, 0, 1'b0, 0, "R8");        // empty window
    runWalk(4, 6, 1'b1, 0, 1'b0, 0, "R6");        // skipped walk
    runWalk(8, 6, 1'b0, 2, 1'b1, 6, "R7");        // start while busy, R4 via ready
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule